// File: doc/BRIEF.md
# Paired-Channel PWM Tick Prescaler

This block turns two free-running source strobes into one count-enable tick per PWM channel. The channels are grouped in pairs: channel c belongs to pair c>>1. Each pair picks one of the two strobes as its source, either the fixed oscillator strobe or the bus clock strobe. It then divides that source by a power of two, 2^M. Each channel takes its pair's divided tick and divides it again by its own factor K+1. The result is that channel's tick. A channel with its gate bit clear gets nothing. A channel with its bypass bit set gets the raw, undivided source strobe on a separate output, and its normal tick is suppressed.

Everything runs in one system clock domain, and the sources arrive as single-cycle enable strobes. The outputs are combinational functions of the current strobes and the counter state. A tick therefore appears in the same cycle as the source strobe that completes it, so a waveform counter downstream can use it directly as a clock enable.

The power-of-two divider of a pair restarts whenever its effective exponent or its effective source changes. A channel's K counter restarts whenever K changes. Because of these restarts, a new setting takes effect from a known phase.

Top module: `pwm_clock_tree`

## Requirements
- R1: While `rst_n` is low, `chan_tick` and `chan_byp_tick` stay all zero whatever the source strobes and configuration are, and every counter is cleared.
- R2: The pair source field is bits 8:7 of that pair's 9-bit word in `pair_cfg`. A value of 0 selects `osc_tick`, and any nonzero value selects `bus_tick`. A change between two nonzero values does not restart the divider.
- R3: The pair exponent M is bits 3:0 of the pair word. The pair emits one divided tick every 2^M selected source strobes, and channels 2n and 2n+1 both use pair n.
- R4: A programmed M above 8 behaves exactly as M = 8. A change between two values of 8 or more does not restart the divider.
- R5: When the effective M or the effective source changes, the pair emits no divided tick in that cycle. Its next divided tick comes on the 2^M-th source strobe after that cycle.
- R6: Channel c's prescale K is bits 7:0 of byte c of `chan_ctl`. With the gate set and bypass clear, `chan_tick[c]` pulses on every (K+1)-th divided tick of its pair, in the same cycle as that divided tick.
- R7: When K changes, channel c emits no tick in that cycle. Its next tick comes on the (K+1)-th divided pair tick after that cycle.
- R8: With gate bit c of `gate_word` clear, channel c emits neither a tick nor a bypass tick, and its K counter holds its count.
- R9: With gate bit c set and bypass bit c+16 of `gate_word` set, `chan_byp_tick[c]` equals the pair's selected undivided source strobe, `chan_tick[c]` stays low, and the K counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator source strobe, one cycle per source edge |
| bus_tick | input | 1 | Bus clock source strobe |
| pair_cfg | input | NUM_PAIRS*9 | Per-pair word: source select at 8:7, exponent M at 3:0 |
| chan_ctl | input | NUM_CH*8 | Per-channel prescale K, one byte per channel |
| gate_word | input | 32 | Gate enable at bit c, bypass at bit c+16 |
| chan_tick | output | NUM_CH | Divided count-enable tick per channel |
| chan_byp_tick | output | NUM_CH | Undivided source strobe per bypassed channel |

## Verification
The assertions check several properties on every cycle:
- each counter is zero in the cycle after a restart;
- the pair counter holds between source strobes;
- a gated or bypassed K counter holds;
- the K count never passes the last accepted K;
- both outputs stay quiet while reset is asserted.

Only the bench scenarios can show the actual division ratios. These are 2^M times K+1, the clamp of M at 8, and the fact that a change between nonzero source codes does not restart the divider. The scenarios also show where the first tick lands after a restart, and that the bypass output follows the raw source. The bench measures these by comparing every output bit against a behavioural model on every cycle, and by counting ticks over fixed windows.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;

   typedef enum logic {
      SRC_OSC = 1'b0,
      SRC_BUS = 1'b1
   } src_e;

   function automatic src_e decode_src(input logic any_set);
      return any_set ? SRC_BUS : SRC_OSC;
   endfunction

endpackage

// File: rtl/pair_divider.sv
module pair_divider
   import pwmclk_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter int DIV_W   = 4,
   parameter int DIV_MAX = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             bus_tick,
   input  logic [SEL_W-1:0] sel,
   input  logic [DIV_W-1:0] div_exp,
   output logic             src_tick,
   output logic             pair_tick
);
   localparam int CNT_W = DIV_MAX;
   localparam int EXP_W = $clog2(DIV_MAX + 1);

   src_e             src_now, src_last;
   logic [EXP_W-1:0] m_eff, m_last;
   logic [CNT_W-1:0] cnt, limit;
   logic             cfg_change, wrap;

   always_comb begin
      src_now    = decode_src(sel != '0);
      src_tick   = (src_now == SRC_BUS) ? bus_tick : osc_tick;
      m_eff      = (div_exp > DIV_W'(DIV_MAX)) ? EXP_W'(DIV_MAX) : EXP_W'(div_exp);
      limit      = CNT_W'((32'd1 << m_eff) - 32'd1);
      cfg_change = (m_eff != m_last) || (src_now != src_last);
      wrap       = (cnt == limit);
      pair_tick  = rst_n && src_tick && !cfg_change && wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         m_last   <= '0;
         src_last <= SRC_OSC;
      end else if (cfg_change) begin
         cnt      <= '0;
         m_last   <= m_eff;
         src_last <= src_now;
      end else if (src_tick) begin
         cnt <= wrap ? '0 : cnt + CNT_W'(1);
      end
   end

   // R5: a configuration change leaves the counter at zero
   assert_restart_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> (cnt == '0));

   // R3: the counter advances only on a selected source strobe
   assert_hold_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!src_tick && !cfg_change) |=> $stable(cnt));

endmodule

// File: rtl/chan_prescaler.sv
module chan_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic             pair_tick,
   input  logic [PRE_W-1:0] presc,
   input  logic             gate_en,
   input  logic             bypass,
   output logic             tick,
   output logic             byp_tick
);
   logic [PRE_W-1:0] kcnt, k_last;
   logic             k_change, active, at_end;

   always_comb begin
      k_change = (presc != k_last);
      active   = gate_en && !bypass;
      at_end   = (kcnt == presc);
      tick     = rst_n && active && pair_tick && !k_change && at_end;
      byp_tick = rst_n && gate_en && bypass && src_tick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kcnt   <= '0;
         k_last <= '0;
      end else if (k_change) begin
         kcnt   <= '0;
         k_last <= presc;
      end else if (active && pair_tick) begin
         kcnt <= at_end ? '0 : kcnt + PRE_W'(1);
      end
   end

   // R7: a new K restarts the count
   assert_restart_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      k_change |=> (kcnt == '0));

   // R8, R9: a gated or bypassed channel keeps its count
   assert_gate_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((!gate_en || bypass) && !k_change) |=> $stable(kcnt));

   // R6: the count never runs past the accepted K
   assert_range_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      kcnt <= k_last);

endmodule

// File: rtl/pwm_clock_tree.sv
module pwm_clock_tree #(
   parameter int NUM_CH  = 8,
   parameter int SEL_LSB = 7,
   parameter int SEL_W   = 2,
   parameter int DIV_W   = 4,
   parameter int DIV_MAX = 8,
   parameter int PRE_W   = 8,
   parameter int GATE_W  = 32,
   parameter int BYP_OFS = 16,
   localparam int NUM_PAIRS  = (NUM_CH + 1) / 2,
   localparam int PAIR_CFG_W = SEL_LSB + SEL_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            osc_tick,
   input  logic                            bus_tick,
   input  logic [NUM_PAIRS*PAIR_CFG_W-1:0] pair_cfg,
   input  logic [NUM_CH*PRE_W-1:0]         chan_ctl,
   input  logic [GATE_W-1:0]               gate_word,
   output logic [NUM_CH-1:0]               chan_tick,
   output logic [NUM_CH-1:0]               chan_byp_tick
);
   if (NUM_CH < 1 || NUM_CH > BYP_OFS || BYP_OFS + NUM_CH > GATE_W) begin : g_bad_ch
      $error("pwm_clock_tree: NUM_CH does not fit the gate word");
   end
   if (SEL_LSB < DIV_W) begin : g_bad_sel
      $error("pwm_clock_tree: source field overlaps exponent field");
   end
   if (DIV_MAX < 1 || DIV_MAX >= (1 << DIV_W)) begin : g_bad_div
      $error("pwm_clock_tree: DIV_MAX out of range for DIV_W");
   end

   logic [NUM_PAIRS-1:0] pair_src;
   logic [NUM_PAIRS-1:0] pair_div;
   wire unused_cfg_bits = ^{pair_cfg, gate_word};

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      pair_divider #(
         .SEL_W  (SEL_W),
         .DIV_W  (DIV_W),
         .DIV_MAX(DIV_MAX)
      ) u_pair (
         .clk      (clk),
         .rst_n    (rst_n),
         .osc_tick (osc_tick),
         .bus_tick (bus_tick),
         .sel      (pair_cfg[p*PAIR_CFG_W+SEL_LSB +: SEL_W]),
         .div_exp  (pair_cfg[p*PAIR_CFG_W +: DIV_W]),
         .src_tick (pair_src[p]),
         .pair_tick(pair_div[p])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      chan_prescaler #(
         .PRE_W(PRE_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_tick (pair_src[c/2]),
         .pair_tick(pair_div[c/2]),
         .presc    (chan_ctl[c*PRE_W +: PRE_W]),
         .gate_en  (gate_word[c]),
         .bypass   (gate_word[c+BYP_OFS]),
         .tick     (chan_tick[c]),
         .byp_tick (chan_byp_tick[c])
      );
   end

   // R1: quiet outputs during reset
   always_comb begin
      if (rst_n == 1'b0) begin
         assert_reset_quiet_R1 : assert ((chan_tick == '0) && (chan_byp_tick == '0))
            else $error("ticks during reset");
      end
   end

endmodule

// File: tb/pwm_clock_tree_test.sv
`timescale 1ns/100ps
module pwm_clock_tree_test;
   localparam int NC = 8;
   localparam int NP = 4;
   localparam int CW = 9;
   localparam int KW = 8;

   logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, bus_tick = 1'b0;
   logic [NP*CW-1:0] pair_cfg = '0;
   logic [NC*KW-1:0] chan_ctl = '0;
   logic [31:0]      gate_word = '0;
   logic [NC-1:0]    chan_tick, chan_byp_tick;

   pwm_clock_tree uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .pair_cfg(pair_cfg), .chan_ctl(chan_ctl), .gate_word(gate_word),
      .chan_tick(chan_tick), .chan_byp_tick(chan_byp_tick)
   );

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   int osc_per = 1, bus_per = 3;
   int m_v[NP], s_v[NP], k_v[NC];
   logic [NC-1:0] g_v = '0, b_v = '0;
   logic rst_req = 1'b1;
   string tag = "R1";
   bit done = 1'b0;

   int pcnt[NP], plm[NP], pls[NP];
   int kc[NC], kl[NC];
   int tick_n[NC], byp_n[NC];

   task automatic check(string req, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic model_step();
      logic [NC-1:0] et, eb;
      logic st[NP];
      logic pt[NP];
      et = '0; eb = '0;
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin pcnt[p] = 0; plm[p] = 0; pls[p] = 0; st[p] = 0; pt[p] = 0; end
         for (int c = 0; c < NC; c++) begin kc[c] = 0; kl[c] = 0; end
      end else begin
         for (int p = 0; p < NP; p++) begin
            int sel, mm;
            bit chg;
            sel = (pair_cfg[p*CW+7 +: 2] != 2'b00) ? 1 : 0;
            mm = int'(pair_cfg[p*CW +: 4]);
            if (mm > 8) mm = 8;
            st[p] = (sel == 1) ? bus_tick : osc_tick;
            chg = (mm != plm[p]) || (sel != pls[p]);
            pt[p] = st[p] && !chg && (pcnt[p] == (1 << mm) - 1);
            if (chg) begin pcnt[p] = 0; plm[p] = mm; pls[p] = sel; end
            else if (st[p]) pcnt[p] = pt[p] ? 0 : pcnt[p] + 1;
         end
         for (int c = 0; c < NC; c++) begin
            int k, p;
            bit g, b, kchg;
            p = c / 2;
            k = int'(chan_ctl[c*KW +: KW]);
            g = gate_word[c];
            b = gate_word[c+16];
            kchg = (k != kl[c]);
            et[c] = g && !b && pt[p] && !kchg && (kc[c] == k);
            eb[c] = g && b && st[p];
            if (kchg) begin kc[c] = 0; kl[c] = k; end
            else if (g && !b && pt[p]) kc[c] = (kc[c] == k) ? 0 : kc[c] + 1;
         end
      end
      check(tag, int'(chan_tick), int'(et), "chan_tick vector");
      check(tag, int'(chan_byp_tick), int'(eb), "chan_byp_tick vector");
      for (int c = 0; c < NC; c++) begin
         tick_n[c] += int'(chan_tick[c]);
         byp_n[c]  += int'(chan_byp_tick[c]);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      rst_n = !rst_req;
      osc_tick = (osc_per != 0) && ((cyc % (osc_per == 0 ? 1 : osc_per)) == 0);
      bus_tick = (bus_per != 0) && ((cyc % (bus_per == 0 ? 1 : bus_per)) == 0);
      for (int p = 0; p < NP; p++)
         pair_cfg[p*CW +: CW] = {2'(s_v[p]), 3'b000, 4'(m_v[p])};
      for (int c = 0; c < NC; c++)
         chan_ctl[c*KW +: KW] = 8'(k_v[c]);
      gate_word = {8'h00, b_v, 8'h00, g_v};
      #1;
      if (!done) model_step();
   end

   task automatic clear_counts();
      for (int c = 0; c < NC; c++) begin tick_n[c] = 0; byp_n[c] = 0; end
   endtask

   task automatic run(int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      for (int p = 0; p < NP; p++) begin m_v[p] = 0; s_v[p] = 0; pcnt[p] = 0; plm[p] = 0; pls[p] = 0; end
      for (int c = 0; c < NC; c++) begin k_v[c] = 0; kc[c] = 0; kl[c] = 0; end
      clear_counts();

      // R1: reset holds everything quiet even with gates, bypass and sources active
      tag = "R1";
      g_v = '1; b_v = 8'h80;
      run(6);
      check("R1", int'(chan_tick), 0, "tick in reset");
      check("R1", tick_n[0] + tick_n[1] + byp_n[7], 0, "ticks counted in reset");

      // R3, R6: base ratios with several pairs active
      @(posedge clk);
      tag = "R6";
      rst_req = 1'b0; b_v = '0;
      m_v[0] = 2; s_v[0] = 0; k_v[0] = 3; k_v[1] = 0;
      m_v[1] = 0; s_v[1] = 1; k_v[2] = 1; k_v[3] = 2;
      m_v[2] = 1; s_v[2] = 0; k_v[4] = 0; k_v[5] = 5;
      m_v[3] = 3; s_v[3] = 2; k_v[6] = 0; k_v[7] = 1;
      clear_counts();
      run(170);
      check("R6", tick_n[0], 10, "ch0 ticks M=2 K=3 over 170");
      check("R3", tick_n[1], 42, "ch1 ticks M=2 K=0 over 170");

      // R2: bus selected by a nonzero code; 2 -> 1 does not restart
      tag = "R2";
      osc_per = 0; bus_per = 1;
      m_v[0] = 0; s_v[0] = 2; k_v[0] = 0; k_v[1] = 0;
      clear_counts();
      run(50);
      check("R2", tick_n[1], 49, "bus source after restart");
      s_v[0] = 1;
      clear_counts();
      run(50);
      check("R2", tick_n[1], 50, "nonzero to nonzero select, no restart");

      // R4: M clamps at 8; 8 -> 12 does not restart
      tag = "R4";
      osc_per = 1; bus_per = 3;
      s_v[0] = 0; m_v[0] = 8;
      run(100);
      m_v[0] = 12;
      clear_counts();
      run(200);
      check("R4", tick_n[1], 1, "M=12 acts as 8 without restart");

      // R5: exponent change restarts the pair counter
      tag = "R5";
      m_v[0] = 2;
      run(2);
      m_v[0] = 3;
      clear_counts();
      run(7);
      check("R5", tick_n[1], 0, "no tick before 8 strobes after restart");
      run(3);
      check("R5", tick_n[1], 1, "first tick 8 strobes after restart");

      // R7: K change restarts the channel counter
      tag = "R7";
      m_v[0] = 0;
      run(5);
      k_v[1] = 3;
      clear_counts();
      run(4);
      check("R7", tick_n[1], 0, "no tick before K+1 pair ticks");
      run(1);
      check("R7", tick_n[1], 1, "first tick after K+1 pair ticks");

      // R8: gate clear silences the channel
      tag = "R8";
      g_v[0] = 1'b0;
      clear_counts();
      run(100);
      check("R8", tick_n[0], 0, "gated channel ticks");
      check("R8", byp_n[0], 0, "gated channel bypass ticks");
      g_v[0] = 1'b1;
      run(20);

      // R9: bypass passes the raw source and suppresses the tick
      tag = "R9";
      b_v[1] = 1'b1;
      clear_counts();
      run(50);
      check("R9", byp_n[1], 50, "bypass strobes equal source strobes");
      check("R9", tick_n[1], 0, "normal tick suppressed under bypass");
      g_v[1] = 1'b0;
      clear_counts();
      run(20);
      check("R8", byp_n[1], 0, "bypass with gate clear");
      b_v[1] = 1'b0; g_v[1] = 1'b1;
      run(40);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule